// File: doc/BRIEF.md
# Selectable-Latency Read Output Control

This block is the read-side output control of one port of a synchronous memory. On every rising clock edge it decodes the two chip enables and the read/write strobe into one of three operations: idle (port not selected), write, or read. It then decides when read data from the memory array reaches the port's output and whether the output driver is on. The memory array and the address logic sit outside this block. The array's read data arrives on `rd_data` during the cycle that follows the edge which registered the read.

A static mode input selects the latency. In flow-through mode the array data passes straight to the output in the cycle after the registering edge. In pipelined mode the data is captured in an output register and appears one cycle later. In that mode the driver turns on only if the port was selected at both of the last two edges. The output enable acts without a clock and can force the driver off at any time.

There is no inout port. `drive_en` stands in for the tri-state enable of the pad. `dout` reads zero whenever `drive_en` is low, so "high-impedance" means `drive_en` = 0 and `dout` = 0.

Top module: `rd_out_ctl`

## Requirements
- R1: While `rst_n` is low, `drive_en` is 0 and `dout` is 0.
- R2: The port is selected only when `ce0_n` = 0 and `ce1` = 1. If an edge registers the port as not selected, `drive_en` is 0 for the cycle after that edge, in both modes.
- R3: A selected edge with `rw` = 0 (write) leaves the driver off in the cycle where its read data would have shown. In flow-through mode that is the cycle after that edge. In pipelined mode it is the cycle after the following edge.
- R4: In flow-through mode (`pipe_mode` = 0), a selected edge with `rw` = 1 (read) sets `drive_en` = 1 for the next cycle. During that cycle `dout` follows `rd_data`.
- R5: In pipelined mode (`pipe_mode` = 1), the data of a read registered at edge k is the `rd_data` value sampled at edge k+1. It is driven during the cycle after edge k+1.
- R6: In pipelined mode the driver is on after edge k+1 only if the port was selected at both edge k and edge k+1. A read followed by a deselect therefore leaves the output off, and the first selected edge after a deselect does not turn it on.
- R7: `oe_n` = 1 forces `drive_en` to 0 at once, without a clock edge. Returning `oe_n` to 0 restores the drive that the registered state calls for, also without a clock edge.
- R8: In pipelined mode, `dout` does not follow changes on `rd_data` between clock edges.
- R9: At an edge where `pipe_mode` differs from its value at the previous edge, all pending reads are dropped. `drive_en` is 0 for the cycle after that edge.
- R10: `dout` is all zeros whenever `drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| rw | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined |
| rd_data | input | DATA_W | Read data from the memory array |
| dout | output | DATA_W | Port output data, zero when not driving |
| drive_en | output | 1 | Output driver enable |

## Verification
The bench builds the block with its default DATA_W of 8. At that width, distinct byte patterns such as A5, 5A and 77 tell apart data that was captured from data that was only passing through. The mode is switched in both directions during the run. This covers the pipeline flush, the two-edge re-enable after a deselect, a write between pipelined reads, and release of the output enable between clock edges.

// File: rtl/rd_out_ctl_pkg.sv
package rd_out_ctl_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } port_op_e;
endpackage

// File: rtl/rd_out_decode.sv
module rd_out_decode
  import rd_out_ctl_pkg::*;
(
  input  logic     ce0_n,
  input  logic     ce1,
  input  logic     rw,
  output port_op_e op
);
  always_comb begin
    if (ce0_n || !ce1) op = OP_IDLE;
    else if (rw)       op = OP_READ;
    else               op = OP_WRITE;
  end
endmodule

// File: rtl/rd_out_stage.sv
// Registered control timing: which read, if any, owns the output.
module rd_out_stage
  import rd_out_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  port_op_e op,
  input  logic     pipe_mode,
  output logic     ft_drive,
  output logic     pp_drive,
  output logic     load_en
);
  logic rd_q1, rd_q2, sel_q1, mode_q;
  logic mode_chg;

  assign mode_chg = (pipe_mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q1  <= 1'b0;
      rd_q2  <= 1'b0;
      sel_q1 <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= pipe_mode;
      sel_q1 <= (op != OP_IDLE);
      if (mode_chg) begin
        rd_q1 <= 1'b0;
        rd_q2 <= 1'b0;
      end else begin
        rd_q1 <= (op == OP_READ);
        rd_q2 <= rd_q1;
      end
    end
  end

  assign ft_drive = rd_q1 & ~mode_q;
  assign pp_drive = rd_q2 & sel_q1 & mode_q;
  assign load_en  = rd_q1;
endmodule

// File: rtl/rd_out_hold.sv
module rd_out_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/rd_out_gate.sv
module rd_out_gate #(
  parameter int DATA_W = 8
) (
  input  logic              ft_drive,
  input  logic              pp_drive,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] pipe_q,
  output logic [DATA_W-1:0] dout,
  output logic              drive_en
);
  logic [DATA_W-1:0] src;

  assign drive_en = (ft_drive | pp_drive) & ~oe_n;
  assign src      = pp_drive ? pipe_q : rd_data;

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    assign dout[b] = src[b] & drive_en;
  end
endmodule

// File: rtl/rd_out_ctl.sv
module rd_out_ctl
  import rd_out_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              rw,
  input  logic              oe_n,
  input  logic              pipe_mode,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              drive_en
);
  port_op_e          op;
  logic              ft_drive, pp_drive, load_en;
  logic [DATA_W-1:0] pipe_q;

  rd_out_decode u_dec (
    .ce0_n (ce0_n),
    .ce1   (ce1),
    .rw    (rw),
    .op    (op)
  );

  rd_out_stage u_stg (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .pipe_mode (pipe_mode),
    .ft_drive  (ft_drive),
    .pp_drive  (pp_drive),
    .load_en   (load_en)
  );

  rd_out_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .d       (rd_data),
    .q       (pipe_q)
  );

  rd_out_gate #(.DATA_W(DATA_W)) u_gate (
    .ft_drive (ft_drive),
    .pp_drive (pp_drive),
    .oe_n     (oe_n),
    .rd_data  (rd_data),
    .pipe_q   (pipe_q),
    .dout     (dout),
    .drive_en (drive_en)
  );
endmodule

// File: rtl/rd_out_ctl_chk.sv
module rd_out_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce0_n,
  input logic              ce1,
  input logic              rw,
  input logic              oe_n,
  input logic              pipe_mode,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] dout,
  input logic              drive_en
);
  logic       sel, wr;
  logic [1:0] cyc;

  assign sel = ~ce0_n & ce1;
  assign wr  = sel & ~rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      reset_quiet_chk: assert (!drive_en && dout == '0);
    end else begin
      // R7
      oe_gate_chk: assert (!(oe_n && drive_en));
      // R10
      zero_when_off_chk: assert (drive_en || dout == '0);
    end
  end

  // R2
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && $past(!sel)) |-> !drive_en);

  // R3
  write_ft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && $past(wr) && !$past(pipe_mode)) |-> !drive_en);

  // R3
  write_pp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(wr, 2) && $past(pipe_mode, 2) && $past(pipe_mode)) |-> !drive_en);

  // R4
  ft_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && drive_en && !$past(pipe_mode)) |-> dout == rd_data);

  // R5
  pp_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && drive_en && $past(pipe_mode)) |-> dout == $past(rd_data));

  // R6
  pp_two_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && drive_en && $past(pipe_mode)) |-> ($past(sel) && $past(sel, 2)));

  // R9
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(pipe_mode) != $past(pipe_mode, 2)) |-> !drive_en);
endmodule

bind rd_out_ctl rd_out_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce0_n     (ce0_n),
  .ce1       (ce1),
  .rw        (rw),
  .oe_n      (oe_n),
  .pipe_mode (pipe_mode),
  .rd_data   (rd_data),
  .dout      (dout),
  .drive_en  (drive_en)
);

// File: tb/rd_out_ctl_test.sv
`timescale 1ns/1ps
module rd_out_ctl_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, ce0_n, ce1, rw, oe_n, pipe_mode;
  logic [W-1:0] rd_data;
  logic [W-1:0] dout;
  logic         drive_en;
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 1'b0;

  always #4 clk = ~clk;

  rd_out_ctl #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .rw(rw),
    .oe_n(oe_n), .pipe_mode(pipe_mode), .rd_data(rd_data),
    .dout(dout), .drive_en(drive_en)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic c0n, input logic c1, input logic r);
    @(negedge clk);
    ce0_n = c0n; ce1 = c1; rw = r;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ce0_n = 1'b0; ce1 = 1'b1; rw = 1'b1; oe_n = 1'b0;
    pipe_mode = 1'b0; rd_data = 8'hFF;
    repeat (3) tick;
    chk("R1 drive_en in reset", 16'(drive_en), 16'h0);
    chk("R1 dout in reset", 16'(dout), 16'h0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_flow_read;
    put(1'b0, 1'b1, 1'b1);
    tick;
    rd_data = 8'hA5; #1;
    chk("R4 ft drive", 16'(drive_en), 16'h1);
    chk("R4 ft data", 16'(dout), 16'h00A5);
    rd_data = 8'h3C; #1;
    chk("R4 ft data follows", 16'(dout), 16'h003C);
  endtask

  task automatic t_decode;
    for (int i = 0; i < 3; i++) begin
      put(i != 1, i == 0, 1'b1);
      tick;
      chk("R2 not selected off", 16'(drive_en), 16'h0);
      chk("R10 dout zero when off", 16'(dout), 16'h0);
    end
    put(1'b0, 1'b1, 1'b1);
    tick;
    chk("R2 selected read on", 16'(drive_en), 16'h1);
  endtask

  task automatic t_write_ft;
    put(1'b0, 1'b1, 1'b0);
    tick;
    chk("R3 ft write off", 16'(drive_en), 16'h0);
  endtask

  task automatic t_oe;
    put(1'b0, 1'b1, 1'b1);
    tick;
    rd_data = 8'h96; #1;
    chk("R7 driving before oe", 16'(drive_en), 16'h1);
    oe_n = 1'b1; #1;
    chk("R7 oe forces off", 16'(drive_en), 16'h0);
    chk("R10 dout zero under oe", 16'(dout), 16'h0);
    oe_n = 1'b0; #1;
    chk("R7 oe release drive", 16'(drive_en), 16'h1);
    chk("R7 oe release data", 16'(dout), 16'h0096);
  endtask

  task automatic t_mode_up;
    @(negedge clk);
    ce0_n = 1'b0; ce1 = 1'b1; rw = 1'b1; pipe_mode = 1'b1;
    tick;
    chk("R9 flush on mode change", 16'(drive_en), 16'h0);
    tick;
    chk("R9 refill cycle off", 16'(drive_en), 16'h0);
    tick;
    chk("R9 pipelined resumes", 16'(drive_en), 16'h1);
  endtask

  task automatic t_pipe_read;
    put(1'b1, 1'b0, 1'b1);
    tick; tick;
    chk("R2 pp deselect off", 16'(drive_en), 16'h0);
    put(1'b0, 1'b1, 1'b1);
    tick;
    rd_data = 8'h5A; #1;
    chk("R6 first selected edge off", 16'(drive_en), 16'h0);
    tick;
    chk("R5 pp drive", 16'(drive_en), 16'h1);
    chk("R5 pp data", 16'(dout), 16'h005A);
    rd_data = 8'h77; #1;
    chk("R8 pp holds data", 16'(dout), 16'h005A);
    tick;
    chk("R5 pp next data", 16'(dout), 16'h0077);
  endtask

  task automatic t_pipe_reenable;
    put(1'b1, 1'b1, 1'b1);
    tick;
    chk("R6 read then deselect off", 16'(drive_en), 16'h0);
    put(1'b0, 1'b1, 1'b1);
    tick;
    chk("R6 one selected edge off", 16'(drive_en), 16'h0);
    tick;
    chk("R6 two selected edges on", 16'(drive_en), 16'h1);
  endtask

  task automatic t_write_pp;
    put(1'b0, 1'b1, 1'b0);
    tick;
    chk("R5 prior read shows in write cycle", 16'(drive_en), 16'h1);
    put(1'b0, 1'b1, 1'b1);
    tick;
    chk("R3 pp write slot off", 16'(drive_en), 16'h0);
    tick;
    chk("R5 pp read after write on", 16'(drive_en), 16'h1);
  endtask

  task automatic t_mode_down;
    @(negedge clk) pipe_mode = 1'b0;
    tick;
    chk("R9 flush to flow-through", 16'(drive_en), 16'h0);
    tick;
    rd_data = 8'hC3; #1;
    chk("R9 ft resumes drive", 16'(drive_en), 16'h1);
    chk("R9 ft resumes data", 16'(dout), 16'h00C3);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      report;
    end
  end

  initial begin
    t_reset;
    t_flow_read;
    t_decode;
    t_write_ft;
    t_oe;
    t_mode_up;
    t_pipe_read;
    t_pipe_reenable;
    t_write_pp;
    t_mode_down;
    done = 1'b1;
    report;
  end
endmodule